// File: doc/BRIEF.md
# Paged Fetch-Address Controller with Wrapping Return Stack

This block holds the 13-bit fetch address of a small accumulator-style processor core and decides, each clock, where the next fetch goes. The core's decoder gives it single-cycle strobes: step to the next word, overwrite the low byte from the data path, jump or call to an 11-bit immediate, return from a subroutine, or take the interrupt vector. A 5-bit page latch, written elsewhere in the core, supplies the bits above the immediate or above the low byte. The latch is used in full for a low-byte write, and only its top two bits for a jump or call.

Calls and interrupt entries save a return address in an 8-entry last-in first-out store. Returns take the saved address back out. The store has no depth tracking. Its index is a 3-bit counter that wraps in both directions, so deep nesting silently overwrites the oldest entries and extra returns read whatever slot the index lands on. The core sees only the full fetch address and a copy of it cut to the width of the memory that is actually fitted.

A priority decoder turns the strobes into one operation per cycle. The operations are HOLD, INC, WRLOW, JUMP, CALL, RET and VEC. Every cycle is an independent transition from the current address to the next one, chosen by the winning operation. No operation depends on an earlier one except through the stack contents.

Top module: `pcu_fetch_ctrl`

## Requirements
- R1: While `rst_n` is low, `fetch_addr_o` is 0000h, the stack index is 0, and every stack slot is zero. A return taken right after reset therefore goes to 0000h.
- R2: An INC cycle (only `inc_i` set) makes the next address the current one plus 1, modulo 2^13, so 1FFFh is followed by 0000h.
- R3: A WRLOW cycle loads address bits [7:0] from `low_data_i` and bits [12:8] from `page_latch_i[4:0]`.
- R4: A JUMP cycle loads address bits [10:0] from `target_i` and bits [12:11] from `page_latch_i[4:3]`. Latch bits [2:0] have no effect on the result.
- R5: A CALL cycle loads the same address a JUMP would. It also pushes the current address plus 1, modulo 2^13, onto the stack.
- R6: A RET cycle loads the full 13-bit address on top of the stack and pops it. The page latch plays no part in the result.
- R7: A VEC cycle loads 0004h and pushes the current address, which was not executed.
- R8: The stack holds 8 entries and wraps. The ninth push overwrites the first entry and the tenth overwrites the second. Eight pops after ten pushes return pushes 10 down to 3, and a ninth pop returns push 10 again.
- R9: When several strobes are set in the same cycle, exactly one wins, in this order: `vec_i`, `ret_i`, `call_i`, `jump_i`, `low_wr_i`, `inc_i`.
- R10: `mem_addr_o` always equals the low `IMPL_AW` bits of `fetch_addr_o` (12 by default). An address above the fitted memory therefore wraps onto it.
- R11: In a HOLD cycle (no strobe set), the address and the stack keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Step to next word |
| low_wr_i | input | 1 | Overwrite low byte |
| low_data_i | input | 8 | Low-byte value |
| jump_i | input | 1 | Jump to immediate |
| call_i | input | 1 | Call to immediate |
| target_i | input | 11 | Jump or call immediate |
| ret_i | input | 1 | Return from subroutine |
| vec_i | input | 1 | Take interrupt vector |
| page_latch_i | input | 5 | Upper-address latch |
| fetch_addr_o | output | 13 | Current fetch address |
| mem_addr_o | output | 12 | Fetch address cut to fitted memory |

## Verification
The bench pushes ten nested calls and pops nine times. A stack with a saturating index or a missing wrap would return stale or wrong addresses on the last pops. It sets latch bits that a jump must ignore and writes low bytes under every latch bit, so a design that swaps which latch bits are used shows a wrong page. It asserts several strobes together to catch a wrong priority order, and takes a return right after reset, where a design that does not clear the stack or its index returns a nonzero address. It also steps across 1FFFh to check wrap of the increment and of the fitted-memory address.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_INC   = 3'd1,
        OP_WRLOW = 3'd2,
        OP_JUMP  = 3'd3,
        OP_CALL  = 3'd4,
        OP_RET   = 3'd5,
        OP_VEC   = 3'd6
    } pc_op_e;
endpackage

// File: rtl/pcu_op_decode.sv
module pcu_op_decode
    import pcu_pkg::*;
(
    input  logic   vec_i,
    input  logic   ret_i,
    input  logic   call_i,
    input  logic   jump_i,
    input  logic   low_wr_i,
    input  logic   inc_i,
    output pc_op_e op_o
);
    logic [5:0] req;
    assign req = {vec_i, ret_i, call_i, jump_i, low_wr_i, inc_i};

    // R9: fixed priority, vector highest, increment lowest
    always_comb begin
        priority casez (req)
            6'b1?????: op_o = OP_VEC;
            6'b01????: op_o = OP_RET;
            6'b001???: op_o = OP_CALL;
            6'b0001??: op_o = OP_JUMP;
            6'b00001?: op_o = OP_WRLOW;
            6'b000001: op_o = OP_INC;
            default:   op_o = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
    import pcu_pkg::*;
#(
    parameter int PC_W     = 13,
    parameter int LOW_W    = 8,
    parameter int TGT_W    = 11,
    parameter int LATCH_W  = 5,
    parameter int VEC_ADDR = 4
) (
    input  pc_op_e             op_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [LATCH_W-1:0] latch_i,
    input  logic [LOW_W-1:0]   low_data_i,
    input  logic [TGT_W-1:0]   target_i,
    input  logic [PC_W-1:0]    stack_top_i,
    output logic [PC_W-1:0]    pc_next_o,
    output logic               push_o,
    output logic               pop_o,
    output logic [PC_W-1:0]    push_data_o
);
    localparam int HI_W = PC_W - LOW_W;
    localparam int PG_W = PC_W - TGT_W;

    logic [PC_W-1:0] pc_plus1;
    logic [PC_W-1:0] paged_target;
    logic [PC_W-1:0] low_loaded;

    assign pc_plus1     = pc_i + PC_W'(1);
    assign paged_target = {latch_i[HI_W-1 -: PG_W], target_i};
    assign low_loaded   = {latch_i[HI_W-1:0], low_data_i};

    always_comb begin
        pc_next_o   = pc_i;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_data_o = pc_plus1;
        unique case (op_i)
            OP_HOLD:  pc_next_o = pc_i;
            OP_INC:   pc_next_o = pc_plus1;
            OP_WRLOW: pc_next_o = low_loaded;
            OP_JUMP:  pc_next_o = paged_target;
            OP_CALL: begin
                pc_next_o   = paged_target;
                push_o      = 1'b1;
                push_data_o = pc_plus1;
            end
            OP_RET: begin
                pc_next_o = stack_top_i;
                pop_o     = 1'b1;
            end
            OP_VEC: begin
                pc_next_o   = PC_W'(VEC_ADDR);
                push_o      = 1'b1;
                push_data_o = pc_i;
            end
            default:  pc_next_o = pc_i;
        endcase
    end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o
);
    localparam int SP_W = $clog2(DEPTH);

    logic [SP_W-1:0] sp_q;
    logic [W-1:0]    slot_q [DEPTH];

    // index wraps in both directions; no depth tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push_i) begin
            sp_q <= sp_q + SP_W'(1);
        end else if (pop_i) begin
            sp_q <= sp_q - SP_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (push_i && (sp_q == SP_W'(g))) begin
                slot_q[g] <= push_data_i;
            end
        end
    end

    assign top_o = slot_q[sp_q - SP_W'(1)];

    // R5 R7
    push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(push_data_i));

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(top_o));
endmodule

// File: rtl/pcu_fetch_ctrl.sv
module pcu_fetch_ctrl
    import pcu_pkg::*;
#(
    parameter int PC_W        = 13,
    parameter int LOW_W       = 8,
    parameter int TGT_W       = 11,
    parameter int LATCH_W     = 5,
    parameter int STACK_DEPTH = 8,
    parameter int VEC_ADDR    = 4,
    parameter int IMPL_AW     = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_i,
    input  logic               low_wr_i,
    input  logic [LOW_W-1:0]   low_data_i,
    input  logic               jump_i,
    input  logic               call_i,
    input  logic [TGT_W-1:0]   target_i,
    input  logic               ret_i,
    input  logic               vec_i,
    input  logic [LATCH_W-1:0] page_latch_i,
    output logic [PC_W-1:0]    fetch_addr_o,
    output logic [IMPL_AW-1:0] mem_addr_o
);
    localparam int HI_W = PC_W - LOW_W;
    localparam int PG_W = PC_W - TGT_W;

    pc_op_e          op;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] stack_top;
    logic [PC_W-1:0] push_data;
    logic            push;
    logic            pop;

    pcu_op_decode u_dec (
        .vec_i    (vec_i),
        .ret_i    (ret_i),
        .call_i   (call_i),
        .jump_i   (jump_i),
        .low_wr_i (low_wr_i),
        .inc_i    (inc_i),
        .op_o     (op)
    );

    pcu_next_addr #(
        .PC_W     (PC_W),
        .LOW_W    (LOW_W),
        .TGT_W    (TGT_W),
        .LATCH_W  (LATCH_W),
        .VEC_ADDR (VEC_ADDR)
    ) u_next (
        .op_i        (op),
        .pc_i        (pc_q),
        .latch_i     (page_latch_i),
        .low_data_i  (low_data_i),
        .target_i    (target_i),
        .stack_top_i (stack_top),
        .pc_next_o   (pc_d),
        .push_o      (push),
        .pop_o       (pop),
        .push_data_o (push_data)
    );

    pcu_ret_stack #(
        .DEPTH (STACK_DEPTH),
        .W     (PC_W)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .top_o       (stack_top)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign fetch_addr_o = pc_q;
    assign mem_addr_o   = pc_q[IMPL_AW-1:0];

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC) |=> fetch_addr_o == $past(fetch_addr_o) + PC_W'(1));

    // R3
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRLOW) |=> fetch_addr_o == {$past(page_latch_i[HI_W-1:0]), $past(low_data_i)});

    // R4 R5
    page_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JUMP || op == OP_CALL) |=>
            fetch_addr_o == {$past(page_latch_i[HI_W-1 -: PG_W]), $past(target_i)});

    // R6
    ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RET) |=> fetch_addr_o == $past(stack_top));

    // R7
    vec_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_VEC) |=> fetch_addr_o == PC_W'(VEC_ADDR));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(fetch_addr_o));
endmodule

// File: tb/pcu_fetch_ctrl_bench.sv
module pcu_fetch_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [12:0] pc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_i = 1'b0, low_wr_i = 1'b0, jump_i = 1'b0, call_i = 1'b0;
    logic        ret_i = 1'b0, vec_i = 1'b0;
    logic [7:0]  low_data_i = '0;
    logic [10:0] target_i = '0;
    logic [4:0]  page_latch_i = '0;
    logic [12:0] fetch_addr_o;
    logic [11:0] mem_addr_o;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];

    logic [12:0] m_pc;
    logic [12:0] m_stk [8];
    int          m_sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcu_fetch_ctrl u_pcu_fetch_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .inc_i        (inc_i),
        .low_wr_i     (low_wr_i),
        .low_data_i   (low_data_i),
        .jump_i       (jump_i),
        .call_i       (call_i),
        .target_i     (target_i),
        .ret_i        (ret_i),
        .vec_i        (vec_i),
        .page_latch_i (page_latch_i),
        .fetch_addr_o (fetch_addr_o),
        .mem_addr_o   (mem_addr_o)
    );

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares one expected item per clock, after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                check(it.tag, fetch_addr_o, it.pc);
                check({it.tag, " R10"}, {1'b0, mem_addr_o}, {1'b0, it.pc[11:0]});
            end
        end
    end

    task automatic model_reset();
        m_pc = '0;
        m_sp = 0;
        for (int k = 0; k < 8; k++) m_stk[k] = '0;
    endtask

    // driver: applies strobes for one cycle and queues the expected address
    task automatic drive(input bit v, input bit r, input bit c, input bit j,
                         input bit w, input bit i, input logic [7:0] d,
                         input logic [10:0] t, input logic [4:0] l, input string tag);
        exp_t it;
        @(negedge clk);
        vec_i = v; ret_i = r; call_i = c; jump_i = j; low_wr_i = w; inc_i = i;
        low_data_i = d; target_i = t; page_latch_i = l;
        if (v) begin
            m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_pc = 13'h0004;
        end else if (r) begin
            m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp];
        end else if (c) begin
            m_stk[m_sp] = m_pc + 13'd1; m_sp = (m_sp + 1) % 8; m_pc = {l[4:3], t};
        end else if (j) begin
            m_pc = {l[4:3], t};
        end else if (w) begin
            m_pc = {l, d};
        end else if (i) begin
            m_pc = m_pc + 13'd1;
        end
        it.pc = m_pc;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 0, 0, 0, 0, 8'h00, 11'h000, 5'h00, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vec_i = 0; ret_i = 0; call_i = 0; jump_i = 0; low_wr_i = 0; inc_i = 0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        check("R1 reset address", fetch_addr_o, 13'h0000);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R2 increments
        drive(0,0,0,0,0,1, 8'h00, 11'h000, 5'h00, "R2 inc 1");
        drive(0,0,0,0,0,1, 8'h00, 11'h000, 5'h00, "R2 inc 2");
        idle("R11 hold");
        // R3 low write uses all latch bits
        drive(0,0,0,0,1,0, 8'h37, 11'h000, 5'h1A, "R3 low write");
        drive(0,0,0,0,1,0, 8'hC4, 11'h000, 5'h05, "R3 low write 2");
        // R4 jump: latch[2:0] must not matter
        drive(0,0,0,1,0,0, 8'h00, 11'h123, 5'h15, "R4 jump page 2");
        drive(0,0,0,1,0,0, 8'h00, 11'h000, 5'h0F, "R4 jump latch low ignored");
        // R5 call / R6 return
        drive(0,0,1,0,0,0, 8'h00, 11'h456, 5'h1F, "R5 call");
        drive(0,0,0,0,0,1, 8'h00, 11'h000, 5'h00, "R2 inc in callee");
        drive(1'b0,1'b1,0,0,0,0, 8'h00, 11'h000, 5'h08, "R6 return");
        // R7 vector and return
        drive(1,0,0,0,0,0, 8'h00, 11'h000, 5'h00, "R7 vector");
        drive(0,1,0,0,0,0, 8'h00, 11'h000, 5'h13, "R7 R6 return from vector");
        // R2 R10 wrap at top of space
        drive(0,0,0,0,1,0, 8'hFF, 11'h000, 5'h1F, "R10 top address");
        drive(0,0,0,0,0,1, 8'h00, 11'h000, 5'h00, "R2 wrap to zero");
        // R8 ten nested calls then nine returns
        for (int k = 0; k < 10; k++)
            drive(0,0,1,0,0,0, 8'h00, 11'(k * 37 + 5), 5'(k * 8), "R8 push");
        for (int k = 0; k < 9; k++)
            drive(0,1,0,0,0,0, 8'h00, 11'h000, 5'h00, "R8 pop");
        // R9 priority combinations
        drive(1,1,1,1,1,1, 8'hAA, 11'h155, 5'h1F, "R9 vector wins");
        drive(0,1,1,1,1,1, 8'hAA, 11'h155, 5'h1F, "R9 return over call");
        drive(0,0,1,1,1,1, 8'hAA, 11'h2AA, 5'h10, "R9 call over jump");
        drive(0,0,0,1,1,1, 8'hAA, 11'h7FF, 5'h08, "R9 jump over low write");
        drive(0,0,0,0,1,1, 8'h5A, 11'h000, 5'h0C, "R9 low write over inc");
        drive(0,1,0,0,0,0, 8'h00, 11'h000, 5'h00, "R9 call pushed once");
        idle("R11 hold 2");
        // R1 reset clears stack: return after reset goes to 0
        do_reset();
        drive(0,1,0,0,0,0, 8'h00, 11'h000, 5'h1F, "R1 return after reset");
        idle("R11 hold 3");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule